// File: doc/BRIEF.md
# CSI-2 Long Packet Type Filter

This block sits after the stage that pulls CSI-2 long packets out of the lane stream. It looks at each packet's header and decides whether the packet goes on to the pixel path. Three kinds of packet are kept:

- packets whose data type equals the one pixel format chosen at build time;
- 8-bit raw packets;
- packets with a user-defined type.

Any other packet is removed whole, payload beats included. A packet is also removed when its virtual channel lies beyond the number of channels the build supports, and that case raises a sticky error flag.

The stream uses one 32-bit bus with valid, ready and last. The first beat of a packet is its header. Header fields:

| Bits | Field |
|------|-------|
| [5:0] | data type |
| [11:8] | virtual channel |
| [31:16] | word count |

The beats that follow are payload, and the packet ends on the beat with last set. A kept packet goes through unchanged, header beat included. Each of its beats carries the packet's data type and virtual channel on sideband outputs. A removed packet is still accepted upstream at full rate, so it never holds up the stream.

Top module: `csi_dt_filter`

## Requirements
- R1: The first beat after reset, and the first beat after any beat with last set, is a header. Its data type is in_data[5:0] and its virtual channel is in_data[11:8]. A packet whose data type equals PIXEL_DT (default 0x2B) and whose channel is in range is forwarded, every beat from header to last.
- R2: A packet of data type 0x2A (8-bit raw) with an in-range channel is forwarded, whatever PIXEL_DT is.
- R3: A packet of data type 0x30 through 0x37 (user-defined) with an in-range channel is forwarded.
- R4: A packet of any other data type (for example 0x2C, 0x2F, 0x38, 0x10) never raises out_valid on any of its beats.
- R5: While a dropped packet's beats are presented, in_ready is 1 on every beat, even with out_ready held at 0.
- R6: For a forwarded beat, in_ready equals out_ready. out_data and out_last equal in_data and in_last in the same cycle.
- R7: out_dt and out_vc carry the header's data type and channel on every beat of a forwarded packet.
- R8: A header whose channel is NUM_VC or above (NUM_VC default 4; build values 4 or 16) drops its packet. It also sets vc_err, which stays 1 until reset.
- R9: After reset, out_valid is 0 while in_valid is 0, and vc_err is 0.
- R10: The keep-or-drop decision is taken on the header alone and held to the last beat. Payload words whose low bits look like a kept or dropped type do not change it.
- R11: A header-only packet (last set on the header beat) is handled as a complete packet, and the next beat is a header again.
- R12: If PIXEL_DT is not a legal pixel code (0x1E, 0x1F, 0x20–0x24, 0x28–0x2F), only 8-bit raw and user-defined packets are forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted |
| in_data | input | 32 | Header or payload word |
| in_last | input | 1 | Final beat of a packet |
| out_valid | output | 1 | Forwarded beat valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 32 | Forwarded word |
| out_last | output | 1 | Final beat of a forwarded packet |
| out_dt | output | 6 | Data type of the current forwarded packet |
| out_vc | output | 4 | Virtual channel of the current forwarded packet |
| vc_err | output | 1 | Sticky flag for a channel out of range |

## Verification
The only state is the header/payload position and the held decision. If either is wrong, the error shows up at the ports within one beat. A payload word read as a header makes a dropped packet surface, or a kept packet lose beats, on the very next transfer. A stale decision shows as out_valid on a packet that should be dropped, or as in_ready following out_ready when it should be held high. Sideband drift shows as out_dt or out_vc changing in the middle of a packet.

// File: rtl/csi_filt_pkg.sv
// Shared widths, codes and classification helpers for the CSI-2 type filter.
// Assumes 6-bit data types and 4-bit virtual channel identifiers.
package csi_filt_pkg;
    localparam int DT_W = 6;
    localparam int VC_W = 4;

    typedef logic [DT_W-1:0] dt_t;
    typedef logic [VC_W-1:0] vc_t;

    localparam dt_t DT_RAW8 = 6'h2A;

    // True when the code names one of the selectable pixel formats.
    function automatic logic is_pixel_code(input dt_t dt);
        return (dt == 6'h1E) || (dt == 6'h1F) ||
               ((dt >= 6'h20) && (dt <= 6'h24)) ||
               ((dt >= 6'h28) && (dt <= 6'h2F));
    endfunction

    // True for the user-defined range 0x30..0x37.
    function automatic logic is_user_code(input dt_t dt);
        return dt[5:3] == 3'b110;
    endfunction
endpackage

// File: rtl/csi_dt_classifier.sv
// Decides from one header whether its packet is kept.
// Purely combinational; assumes the caller presents only header fields.
module csi_dt_classifier
    import csi_filt_pkg::*;
#(
    parameter dt_t PIXEL_DT = 6'h2B,
    parameter int  NUM_VC   = 4
) (
    input  dt_t  dt,
    input  vc_t  vc,
    output logic keep,
    output logic vc_bad
);
    localparam logic          CFG_OK = is_pixel_code(PIXEL_DT);
    localparam logic [VC_W:0] VC_LIM = NUM_VC[VC_W:0];

    logic pix_match;

    // Pixel match exists only when the configured code is a legal pixel format.
    generate
        if (CFG_OK) begin : g_pix
            assign pix_match = (dt == PIXEL_DT);
        end else begin : g_nopix
            assign pix_match = 1'b0;
        end
    endgenerate

    // Combine channel range and type classes into one verdict.
    always_comb begin
        vc_bad = ({1'b0, vc} >= VC_LIM);
        keep   = !vc_bad && (pix_match || (dt == DT_RAW8) || is_user_code(dt));
    end
endmodule

// File: rtl/csi_pkt_tracker.sv
// Tracks header/payload position and holds the verdict and sideband of
// the packet in flight. Assumes beat_fire is a completed upstream handshake.
module csi_pkt_tracker
    import csi_filt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_fire,
    input  logic in_last,
    input  logic hdr_keep,
    input  logic hdr_vc_bad,
    input  dt_t  hdr_dt,
    input  vc_t  hdr_vc,
    output logic busy,
    output logic keep_q,
    output dt_t  dt_q,
    output vc_t  vc_q,
    output logic vc_err
);
    // Packet position, held verdict and held sideband.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            keep_q <= 1'b0;
            dt_q   <= '0;
            vc_q   <= '0;
        end else if (beat_fire) begin
            if (!busy) begin
                if (!in_last) begin
                    busy   <= 1'b1;
                    keep_q <= hdr_keep;
                    dt_q   <= hdr_dt;
                    vc_q   <= hdr_vc;
                end
            end else if (in_last) begin
                busy <= 1'b0;
            end
        end
    end

    // Sticky channel-range error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc_err <= 1'b0;
        end else if (beat_fire && !busy && hdr_vc_bad) begin
            vc_err <= 1'b1;
        end
    end
endmodule

// File: rtl/csi_dt_filter.sv
// Top of the CSI-2 long packet type filter. Kept packets pass through with
// no added latency; dropped packets are consumed at full rate.
// Assumes the first beat after reset is a header.
module csi_dt_filter
    import csi_filt_pkg::*;
#(
    parameter dt_t PIXEL_DT = 6'h2B,
    parameter int  NUM_VC   = 4,
    parameter int  DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [DT_W-1:0]   out_dt,
    output logic [VC_W-1:0]   out_vc,
    output logic              vc_err
);
    localparam int DT_LSB = 0;
    localparam int VC_LSB = 8;

    dt_t  hdr_dt;
    vc_t  hdr_vc;
    logic hdr_keep, hdr_vc_bad;
    logic busy, keep_q, cur_keep, beat_fire;
    dt_t  dt_q;
    vc_t  vc_q;

    // Header field extraction.
    always_comb begin
        hdr_dt = in_data[DT_LSB +: DT_W];
        hdr_vc = in_data[VC_LSB +: VC_W];
    end

    csi_dt_classifier #(.PIXEL_DT(PIXEL_DT), .NUM_VC(NUM_VC)) u_cls (
        .dt     (hdr_dt),
        .vc     (hdr_vc),
        .keep   (hdr_keep),
        .vc_bad (hdr_vc_bad)
    );

    csi_pkt_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_fire  (beat_fire),
        .in_last    (in_last),
        .hdr_keep   (hdr_keep),
        .hdr_vc_bad (hdr_vc_bad),
        .hdr_dt     (hdr_dt),
        .hdr_vc     (hdr_vc),
        .busy       (busy),
        .keep_q     (keep_q),
        .dt_q       (dt_q),
        .vc_q       (vc_q),
        .vc_err     (vc_err)
    );

    // Route each beat: pass-through when kept, absorb when dropped.
    always_comb begin
        cur_keep  = busy ? keep_q : hdr_keep;
        out_valid = in_valid && cur_keep;
        in_ready  = cur_keep ? out_ready : 1'b1;
        beat_fire = in_valid && in_ready;
        out_data  = in_data;
        out_last  = in_last;
        out_dt    = busy ? dt_q : hdr_dt;
        out_vc    = busy ? vc_q : hdr_vc;
    end
endmodule

// File: rtl/csi_dt_filter_chk.sv
// Port-level checker for csi_dt_filter, attached by bind.
module csi_dt_filter_chk
    import csi_filt_pkg::*;
#(
    parameter dt_t PIXEL_DT = 6'h2B,
    parameter int  NUM_VC   = 4,
    parameter int  DATA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic [DT_W-1:0]   out_dt,
    input logic [VC_W-1:0]   out_vc,
    input logic              vc_err
);
    logic type_ok;

    // Independent view of which types may appear at the output.
    always_comb begin
        type_ok = (is_pixel_code(PIXEL_DT) && (out_dt == PIXEL_DT)) ||
                  (out_dt == DT_RAW8) || is_user_code(out_dt);
    end

    assert_drop_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_valid) |-> in_ready);

    assert_fwd_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready));

    assert_fwd_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data == in_data) && (out_last == in_last)));

    // Covers R1, R2, R3, R12: only accepted classes reach the output.
    assert_type_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> type_ok);

    assert_vc_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_vc} < NUM_VC[VC_W:0]));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vc_err |=> vc_err);

    assert_side_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            (!out_valid || ($stable(out_dt) && $stable(out_vc))));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !vc_err);
endmodule

bind csi_dt_filter csi_dt_filter_chk #(
    .PIXEL_DT(PIXEL_DT), .NUM_VC(NUM_VC), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_dt(out_dt), .out_vc(out_vc), .vc_err(vc_err)
);

// File: tb/tb_csi_dt_filter.sv
`timescale 1ns/1ps
module tb_csi_dt_filter;
    typedef struct {
        logic [31:0] d;
        logic        l;
        logic [5:0]  dt;
        logic [3:0]  vc;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, out_last, vc_err;
    logic [31:0] out_data;
    logic [5:0]  out_dt;
    logic [3:0]  out_vc;

    logic        b_ready, b_valid, b_last, b_err;
    logic [31:0] b_data;
    logic [5:0]  b_dt;
    logic [3:0]  b_vc;

    int    checks = 0;
    int    failures = 0;
    int    bad_cnt = 0;
    bit    bp_en = 0;
    bit    force_stall = 0;
    logic [15:0] lfsr = 16'hACE1;
    beat_t q[$];

    always #2 clk = ~clk;

    csi_dt_filter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .out_dt(out_dt), .out_vc(out_vc), .vc_err(vc_err)
    );

    // Instance with an illegal pixel code (R12).
    csi_dt_filter #(.PIXEL_DT(6'h15)) dut_bad (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(b_valid),
        .out_ready(out_ready), .out_data(b_data), .out_last(b_last),
        .out_dt(b_dt), .out_vc(b_vc), .vc_err(b_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_keep(input logic [5:0] dt, input logic [3:0] vc);
        return (vc < 4) && ((dt == 6'h2B) || (dt == 6'h2A) ||
                            ((dt >= 6'h30) && (dt <= 6'h37)));
    endfunction

    // Downstream ready generator.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= force_stall ? 1'b0 : (bp_en ? (lfsr[0] | lfsr[3]) : 1'b1);
    end

    // Monitor: pops expected beats and compares them as they transfer.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (b_valid) bad_cnt++;
            if (out_valid && q.size() == 0)
                chk(0, "R4", "unexpected out_valid", out_data, 32'h0);
            else if (out_valid && out_ready) begin
                beat_t e;
                e = q.pop_front();
                chk(out_data == e.d && out_last == e.l, "R1/R6", "data/last",
                    {out_last, out_data[30:0]}, {e.l, e.d[30:0]});
                chk(out_dt == e.dt && out_vc == e.vc, "R7", "sideband",
                    {22'h0, out_vc, out_dt}, {22'h0, e.vc, e.dt});
            end
        end
    end

    // Driver: sends one packet and queues the beats expected at the output.
    task automatic send_pkt(input logic [5:0] dt, input logic [3:0] vc,
                            input int npay, input logic [31:0] base);
        bit keep;
        keep = exp_keep(dt, vc);
        for (int i = 0; i <= npay; i++) begin
            beat_t b;
            b.d  = (i == 0) ? {16'(npay * 4), 4'h0, vc, 2'b00, dt} : base + 32'(i);
            b.l  = (i == npay);
            b.dt = dt;
            b.vc = vc;
            if (keep) q.push_back(b);
        end
        for (int i = 0; i <= npay; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = (i == 0) ? {16'(npay * 4), 4'h0, vc, 2'b00, dt} : base + 32'(i);
            in_last  = (i == npay);
            #1;
            if (!keep) chk(in_ready, "R5", "drop ready", {31'h0, in_ready}, 32'h1);
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 60 && q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(q.size() == 0, tag, "all expected beats seen", 32'(q.size()), 32'h0);
    endtask

    task automatic do_reset;
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        chk(out_valid == 1'b0, "R9", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk(vc_err == 1'b0, "R9", "vc_err after reset", {31'h0, vc_err}, 32'h0);

        // R1, R2, R3: accepted classes; R4: boundaries dropped.
        send_pkt(6'h2B, 4'd1, 4, 32'h1000_0000); drain("R1");
        send_pkt(6'h2A, 4'd2, 3, 32'h2000_0000); drain("R2");
        send_pkt(6'h31, 4'd3, 2, 32'h3000_0000); drain("R3");
        send_pkt(6'h37, 4'd0, 2, 32'h3700_0000); drain("R3");
        send_pkt(6'h30, 4'd0, 1, 32'h3100_0000); drain("R3");
        send_pkt(6'h38, 4'd1, 3, 32'h4000_0000); drain("R4");
        send_pkt(6'h2F, 4'd1, 3, 32'h4100_0000); drain("R4");
        send_pkt(6'h2C, 4'd2, 2, 32'h4200_0000); drain("R4");
        // R11: header-only packets.
        send_pkt(6'h2B, 4'd0, 0, 32'h0); drain("R11");
        send_pkt(6'h10, 4'd0, 0, 32'h0);
        send_pkt(6'h2A, 4'd3, 2, 32'h5000_0000); drain("R11");

        // R6: random downstream back-pressure over mixed traffic.
        bp_en = 1;
        for (int k = 0; k < 24; k++) begin
            logic [5:0] t;
            case (k % 6)
                0: t = 6'h2B;
                1: t = 6'h2A;
                2: t = 6'h33;
                3: t = 6'h22;
                4: t = 6'h2E;
                default: t = 6'h36;
            endcase
            send_pkt(t, 4'(k % 4), 1 + (k % 5), 32'(k) << 20);
        end
        drain("R6");
        bp_en = 0;

        // R5: dropped packets are drained while downstream is stalled.
        force_stall = 1;
        repeat (2) @(negedge clk);
        send_pkt(6'h12, 4'd1, 5, 32'h6000_0000);
        send_pkt(6'h24, 4'd0, 3, 32'h6100_0000);
        force_stall = 0;
        drain("R5");

        // R10: payload words that resemble headers do not alter the verdict.
        send_pkt(6'h10, 4'd0, 3, 32'h0000_0029); drain("R10");
        send_pkt(6'h2B, 4'd0, 3, 32'h0000_0011); drain("R10");
        send_pkt(6'h2A, 4'd1, 1, 32'h7000_0000); drain("R10");

        // R8: channel out of range.
        chk(vc_err == 1'b0, "R8", "vc_err before bad vc", {31'h0, vc_err}, 32'h0);
        send_pkt(6'h2A, 4'd4, 3, 32'h8000_0000); drain("R8");
        @(negedge clk); #1;
        chk(vc_err == 1'b1, "R8", "vc_err set", {31'h0, vc_err}, 32'h1);
        send_pkt(6'h2B, 4'd2, 2, 32'h8100_0000); drain("R8");
        send_pkt(6'h31, 4'd15, 2, 32'h8200_0000); drain("R8");
        @(negedge clk); #1;
        chk(vc_err == 1'b1, "R8", "vc_err sticky", {31'h0, vc_err}, 32'h1);

        // R12: illegal pixel code instance forwards only raw8/user types.
        bad_cnt = 0;
        send_pkt(6'h15, 4'd0, 3, 32'h9000_0000); drain("R12");
        chk(bad_cnt == 0, "R12", "illegal code dropped", 32'(bad_cnt), 32'h0);
        bad_cnt = 0;
        send_pkt(6'h2B, 4'd0, 2, 32'h9100_0000); drain("R12");
        chk(bad_cnt == 0, "R12", "pixel match disabled", 32'(bad_cnt), 32'h0);
        bad_cnt = 0;
        send_pkt(6'h2A, 4'd1, 3, 32'h9200_0000); drain("R12");
        chk(bad_cnt == 4, "R12", "raw8 still forwarded", 32'(bad_cnt), 32'h4);

        // R9: reset clears the sticky flag.
        do_reset();
        chk(vc_err == 1'b0, "R9", "vc_err cleared by reset", {31'h0, vc_err}, 32'h0);
        chk(out_valid == 1'b0, "R9", "idle after reset", {31'h0, out_valid}, 32'h0);
        send_pkt(6'h2B, 4'd3, 2, 32'hA000_0000); drain("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule